// File: doc/BRIEF.md
# Two-Digit Decimal Event Counter

This block counts events in decimal from 00 up to 99. Its state is two 4-bit BCD digits, units and tens. Each digit is a small binary counter with a count enable and a synchronous parallel load, and its load data is fixed at zero. A digit returns from 9 to 0 by loading that zero on the clock edge after it reaches its terminal value. No asynchronous reset is involved.

The units digit counts whenever the enable input is high. The tens digit counts only when the units digit sits at 9 and the enable is high. A synchronous clear input drives the load of both digits, so the whole count returns to 00 on the next edge. Clear wins over enable. When the count is at 99 and enable is high, the next edge gives 00. There is no carry output.

Top module: `bcd_pair_counter`

## Requirements
- R1: With `clear` high at a rising edge, both `units_o` and `tens_o` are 0 after that edge.
- R2: Clear takes priority over enable: with `clear` and `cnt_en` both high, the result is 00 and not an incremented value.
- R3: With `clear` low and `cnt_en` low at an edge, both digits keep their values.
- R4: With `cnt_en` high and `units_o` below 9, `units_o` rises by exactly one at the edge.
- R5: With `cnt_en` high and `units_o` equal to 9, `units_o` becomes 0 at the edge.
- R6: With `cnt_en` high and `units_o` equal to 9, `tens_o` rises by one at the edge when it is below 9.
- R7: `tens_o` does not change at an edge where `units_o` is not 9, whatever the enable.
- R8: With `cnt_en` high at count 99 (both digits equal to 9), the count becomes 00 at the edge.
- R9: After the first clear, each digit holds a value between 0 and 9 in binary-coded decimal (4-bit binary weight, values 10 to 15 never appear).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear to 00, active high, takes priority over enable |
| cnt_en | input | 1 | Count enable, active high |
| units_o | output | 4 | Units digit, BCD |
| tens_o | output | 4 | Tens digit, BCD |

## Verification
A directed sweep with the enable held high walks through all 100 states and the wrap from 99 to 00. This separates a correct tens enable from one that fires too early or too late. Random runs mix the enable at about 70 percent with rare clears. These runs show that holds happen at arbitrary counts and that clear and enable raised together give 00 rather than 01 or 10. A short directed segment parks the count at 09, 90 and 99 with enable low, to confirm that no digit moves at the digit boundaries.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 2;
    localparam int LAST_VAL   = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic   en;
        logic   ld;
        digit_t din;
    } digit_ctl_t;

    function automatic logic at_last(input digit_t d);
        return d == digit_t'(LAST_VAL);
    endfunction

endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_pkg::*;
(
    input  logic       clk,
    input  digit_ctl_t ctl,
    output digit_t     q
);

    always_ff @(posedge clk) begin
        if (ctl.ld)
            q <= ctl.din;
        else if (ctl.en)
            q <= q + digit_t'(1);
    end

endmodule

// File: rtl/bcd_chain_ctl.sv
module bcd_chain_ctl
    import bcd_pkg::*;
(
    input  logic       clear,
    input  logic       cnt_en,
    input  digit_t     q   [NUM_DIGITS],
    output digit_ctl_t ctl [NUM_DIGITS]
);

    logic [NUM_DIGITS-1:0] stage_en;

    generate
        for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign stage_en[i] = cnt_en;
            end else begin : g_next
                assign stage_en[i] = stage_en[i-1] & at_last(q[i-1]);
            end
            always_comb begin
                ctl[i].en  = stage_en[i];
                ctl[i].ld  = clear | (stage_en[i] & at_last(q[i]));
                ctl[i].din = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/bcd_pair_counter.sv
module bcd_pair_counter
    import bcd_pkg::*;
(
    input  logic               clk,
    input  logic               clear,
    input  logic               cnt_en,
    output logic [DIGIT_W-1:0] units_o,
    output logic [DIGIT_W-1:0] tens_o
);

    digit_t     q   [NUM_DIGITS];
    digit_ctl_t ctl [NUM_DIGITS];

    bcd_chain_ctl u_ctl (
        .clear  (clear),
        .cnt_en (cnt_en),
        .q      (q),
        .ctl    (ctl)
    );

    generate
        for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
            bcd_digit u_digit (
                .clk (clk),
                .ctl (ctl[i]),
                .q   (q[i])
            );
        end
    endgenerate

    assign units_o = q[0];
    assign tens_o  = q[1];

endmodule

// File: rtl/bcd_pair_counter_chk.sv
module bcd_pair_counter_chk
    import bcd_pkg::*;
(
    input logic               clk,
    input logic               clear,
    input logic               cnt_en,
    input logic [DIGIT_W-1:0] units_o,
    input logic [DIGIT_W-1:0] tens_o
);

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        clear |=> (units_o == '0 && tens_o == '0));

    // R2
    clear_wins_chk: assert property (@(posedge clk)
        (clear && cnt_en) |=> (units_o == '0 && tens_o == '0));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (clear)
        !cnt_en |=> ($stable(units_o) && $stable(tens_o)));

    // R4
    units_step_chk: assert property (@(posedge clk) disable iff (clear)
        (cnt_en && units_o < 4'd9) |=> units_o == $past(units_o) + 4'd1);

    // R5
    units_wrap_chk: assert property (@(posedge clk) disable iff (clear)
        (cnt_en && units_o == 4'd9) |=> units_o == 4'd0);

    // R6
    tens_step_chk: assert property (@(posedge clk) disable iff (clear)
        (cnt_en && units_o == 4'd9 && tens_o < 4'd9) |=> tens_o == $past(tens_o) + 4'd1);

    // R7
    tens_hold_chk: assert property (@(posedge clk) disable iff (clear)
        (units_o != 4'd9) |=> $stable(tens_o));

    // R8
    full_wrap_chk: assert property (@(posedge clk) disable iff (clear)
        (cnt_en && units_o == 4'd9 && tens_o == 4'd9) |=> (units_o == 4'd0 && tens_o == 4'd0));

    // R9
    digit_range_chk: assert property (@(posedge clk) disable iff (clear)
        (units_o <= 4'd9 && tens_o <= 4'd9));

endmodule

bind bcd_pair_counter bcd_pair_counter_chk u_chk (
    .clk     (clk),
    .clear   (clear),
    .cnt_en  (cnt_en),
    .units_o (units_o),
    .tens_o  (tens_o)
);

// File: tb/test_bcd_pair_counter.sv
module test_bcd_pair_counter;

    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] units_o;
    logic [3:0] tens_o;

    int checks = 0;
    int errors = 0;
    int exp_u  = 0;
    int exp_t  = 0;

    always #2 clk = ~clk;

    bcd_pair_counter i_bcd_pair_counter (
        .clk     (clk),
        .clear   (clear),
        .cnt_en  (cnt_en),
        .units_o (units_o),
        .tens_o  (tens_o)
    );

    function automatic string pick_tag(input logic c, input logic e, input int u, input int t);
        if (c && e) return "R2";
        if (c)      return "R1";
        if (!e)     return "R3";
        if (u == 9 && t == 9) return "R8";
        if (u == 9) return "R5/R6";
        return "R4/R7";
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic e);
        string tag;
        @(negedge clk);
        clear  = c;
        cnt_en = e;
        tag = pick_tag(c, e, exp_u, exp_t);
        @(posedge clk);
        if (c) begin
            exp_u = 0;
            exp_t = 0;
        end else if (e) begin
            if (exp_u == 9) begin
                exp_u = 0;
                exp_t = (exp_t == 9) ? 0 : exp_t + 1;
            end else begin
                exp_u = exp_u + 1;
            end
        end
        #1;
        check(tag, int'(units_o), exp_u, "units");
        check(tag, int'(tens_o), exp_t, "tens");
        // R9: digits stay decimal
        if (units_o > 4'd9 || tens_o > 4'd9) begin
            checks++;
            errors++;
            $display("FAIL R9 digit out of range actual=%0d%0d expected<=9", tens_o, units_o);
        end
    endtask

    task automatic park_at(input int t, input int u);
        step(1'b1, 1'b0);
        for (int k = 0; k < t * 10 + u; k++) step(1'b0, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // R4 R5 R6 R8: full sweep through all 100 states and wrap
        for (int k = 0; k < 101; k++) step(1'b0, 1'b1);
        // R3 hold at boundary counts, R7 tens stays put
        park_at(0, 9);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        park_at(9, 0);
        step(1'b0, 1'b0);
        park_at(9, 9);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // R2 clear with enable at a nonzero count
        park_at(4, 9);
        step(1'b1, 1'b1);
        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            logic c;
            logic e;
            c = ($urandom_range(0, 99) < 3);
            e = ($urandom_range(0, 99) < 70);
            step(c, e);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule